// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block turns the opcode and function fields of a fixed-width 32-bit instruction into the control points of a datapath that finishes one instruction per clock. It drives destination-register choice, ALU operand-B choice, write-back source choice, register-file and data-memory write enables, the branch and jump requests, immediate-extension mode and a 3-bit ALU operation code. The block is purely combinational. Its outputs settle in the same cycle in which the instruction word arrives.

Decoding happens in two levels. A primary decoder reads only the 6-bit opcode. It produces every control bit plus a 3-bit ALU class code. A secondary ALU decoder combines that class code with the low bits of the function field to form the ALU operation. Because of this split, the primary table never grows with the function field. The instructions covered are register-register add, subtract, and, or and set-less-than, plus or-immediate, load word, store word, branch-if-equal and jump. The `DECODE_SOP` parameter selects how both levels are built: case tables, or explicit match lines ORed into each output. Both forms behave the same.

Top module: `insn_ctl_dec`

## Requirements
- R1: Opcode 000000 (register-register) drives rd_sel=1, reg_we=1, opb_imm=0, wb_mem=0, mem_we=0, br_req=0, jmp_req=0 and sext=0.
- R2: For opcode 000000, func[3:0] selects alu_op: 0000 gives add (010), 0010 gives sub (110), 0100 gives and (000), 0101 gives or (001), and 1010 gives slt (111). func[5:4] has no effect.
- R3: For opcode 000000 with any other func[3:0], alu_op is add (010) and the other outputs keep their R1 values.
- R4: Opcode 001101 (or-immediate) drives rd_sel=0, opb_imm=1, sext=0, reg_we=1, wb_mem=0, mem_we=0, br_req=0, jmp_req=0 and alu_op=or (001).
- R5: Opcode 100011 (load word) drives rd_sel=0, opb_imm=1, sext=1, wb_mem=1, reg_we=1, mem_we=0, br_req=0, jmp_req=0 and alu_op=add (010).
- R6: Opcode 101011 (store word) drives opb_imm=1, sext=1, mem_we=1, reg_we=0, br_req=0, jmp_req=0, rd_sel=0, wb_mem=0 and alu_op=add (010).
- R7: Opcode 000100 (branch if equal) drives opb_imm=0, br_req=1, sext=1, reg_we=0, mem_we=0, jmp_req=0, rd_sel=0, wb_mem=0 and alu_op=sub (110).
- R8: Opcode 000010 (jump) drives jmp_req=1, reg_we=0, mem_we=0, br_req=0, rd_sel=0, opb_imm=0, wb_mem=0, sext=0 and alu_op=add (010).
- R9: For every opcode other than 000000, no output depends on func.
- R10: Any opcode outside the six listed drives every 1-bit output to 0 and alu_op to add (010), so no architectural state changes.
- R11: For every input, at most one of mem_we, br_req and jmp_req is 1, and reg_we and mem_we are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | OP_W (6) | Instruction opcode field |
| func_i | input | FN_W (6) | Instruction function field |
| rd_sel_o | output | 1 | 1: write the rd register, 0: write the rt register |
| opb_imm_o | output | 1 | 1: ALU operand B is the extended immediate |
| wb_mem_o | output | 1 | 1: write-back data comes from data memory |
| reg_we_o | output | 1 | Register-file write enable |
| mem_we_o | output | 1 | Data-memory write enable |
| br_req_o | output | 1 | Conditional branch request |
| jmp_req_o | output | 1 | Unconditional jump request |
| sext_o | output | 1 | 1: sign-extend the immediate, 0: zero-extend it |
| alu_op_o | output | ACT_W (3) | ALU operation: 000 and, 001 or, 010 add, 110 sub, 111 slt |

## Verification
A full sweep of all 64 opcodes against all 64 function values separates a correct table from a single wrong bit in any row. It also shows whether any non-register opcode reacts to the function field. Directed register-register patterns use each defined low-nibble code under every value of the two upper function bits, then the unused low-nibble codes. This separates nibble-only decoding from full-field decoding, and shows what the default falls back to. Both build variants are driven with the same vectors, and their outputs are compared with each other and with the expected values. A mismatch shows which of the two forms differs.

// File: rtl/insn_ctl_pkg.sv
package insn_ctl_pkg;

   localparam int OPC_W   = 6;
   localparam int FNC_W   = 6;
   localparam int FNLO_W  = 4;
   localparam int AOP_W   = 3;
   localparam int ACT_W   = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_REGREG = 6'b000000,
      OPC_JMP    = 6'b000010,
      OPC_BEQ    = 6'b000100,
      OPC_ORI    = 6'b001101,
      OPC_LDW    = 6'b100011,
      OPC_STW    = 6'b101011
   } opc_e;

   typedef enum logic [AOP_W-1:0] {
      ACLS_ADD  = 3'b000,
      ACLS_SUB  = 3'b001,
      ACLS_OR   = 3'b010,
      ACLS_FUNC = 3'b100
   } acls_e;

   typedef enum logic [ACT_W-1:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_e;

   typedef enum logic [FNLO_W-1:0] {
      FN_ADD = 4'b0000,
      FN_SUB = 4'b0010,
      FN_AND = 4'b0100,
      FN_OR  = 4'b0101,
      FN_SLT = 4'b1010
   } fn_e;

   typedef struct packed {
      logic  rd_sel;
      logic  opb_imm;
      logic  wb_mem;
      logic  reg_we;
      logic  mem_we;
      logic  br_req;
      logic  jmp_req;
      logic  sext;
      acls_e acls;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{rd_sel: 1'b0, opb_imm: 1'b0, wb_mem: 1'b0,
                                 reg_we: 1'b0, mem_we: 1'b0, br_req: 1'b0,
                                 jmp_req: 1'b0, sext: 1'b0, acls: ACLS_ADD};

endpackage

// File: rtl/insn_main_dec.sv
module insn_main_dec
   import insn_ctl_pkg::*;
#(
   parameter int OP_W       = OPC_W,
   parameter bit DECODE_SOP = 1'b0
) (
   input  logic [OP_W-1:0] opcode_i,
   output ctl_t            ctl_o
);

   if (OP_W != OPC_W) begin : g_bad_opw
      $error("insn_main_dec: OP_W must equal the opcode field width");
   end

   if (DECODE_SOP) begin : g_sop
      logic is_rr, is_ori, is_ldw, is_stw, is_beq, is_jmp;

      always_comb begin
         is_rr  = (opcode_i == OPC_REGREG);
         is_ori = (opcode_i == OPC_ORI);
         is_ldw = (opcode_i == OPC_LDW);
         is_stw = (opcode_i == OPC_STW);
         is_beq = (opcode_i == OPC_BEQ);
         is_jmp = (opcode_i == OPC_JMP);
      end

      always_comb begin
         ctl_o         = CTL_IDLE;
         ctl_o.rd_sel  = is_rr;
         ctl_o.opb_imm = is_ori | is_ldw | is_stw;
         ctl_o.wb_mem  = is_ldw;
         ctl_o.reg_we  = is_rr | is_ori | is_ldw;
         ctl_o.mem_we  = is_stw;
         ctl_o.br_req  = is_beq;
         ctl_o.jmp_req = is_jmp;
         ctl_o.sext    = is_ldw | is_stw | is_beq;
         if (is_rr)       ctl_o.acls = ACLS_FUNC;
         else if (is_beq) ctl_o.acls = ACLS_SUB;
         else if (is_ori) ctl_o.acls = ACLS_OR;
         else             ctl_o.acls = ACLS_ADD;
      end
   end else begin : g_table
      always_comb begin
         ctl_o = CTL_IDLE;
         case (opcode_i)
            OPC_REGREG: begin
               ctl_o.rd_sel = 1'b1;
               ctl_o.reg_we = 1'b1;
               ctl_o.acls   = ACLS_FUNC;
            end
            OPC_ORI: begin
               ctl_o.opb_imm = 1'b1;
               ctl_o.reg_we  = 1'b1;
               ctl_o.acls    = ACLS_OR;
            end
            OPC_LDW: begin
               ctl_o.opb_imm = 1'b1;
               ctl_o.wb_mem  = 1'b1;
               ctl_o.reg_we  = 1'b1;
               ctl_o.sext    = 1'b1;
            end
            OPC_STW: begin
               ctl_o.opb_imm = 1'b1;
               ctl_o.mem_we  = 1'b1;
               ctl_o.sext    = 1'b1;
            end
            OPC_BEQ: begin
               ctl_o.br_req = 1'b1;
               ctl_o.sext   = 1'b1;
               ctl_o.acls   = ACLS_SUB;
            end
            OPC_JMP: begin
               ctl_o.jmp_req = 1'b1;
            end
            default: ctl_o = CTL_IDLE;
         endcase
      end
   end

   // R11: the decoded control word never requests two state changes at once
   always_comb begin
      a_r11_one_effect: assert ($onehot0({ctl_o.mem_we, ctl_o.br_req, ctl_o.jmp_req}) &&
                                !(ctl_o.reg_we && ctl_o.mem_we))
         else $error("R11: conflicting control requests for opcode %b", opcode_i);
   end

endmodule

// File: rtl/insn_alu_dec.sv
module insn_alu_dec
   import insn_ctl_pkg::*;
#(
   parameter int AW         = AOP_W,
   parameter int FW         = FNLO_W,
   parameter int CW         = ACT_W,
   parameter bit DECODE_SOP = 1'b0
) (
   input  logic [AW-1:0] acls_i,
   input  logic [FW-1:0] fn_lo_i,
   output logic [CW-1:0] alu_op_o
);

   if (AW != AOP_W || FW != FNLO_W || CW != ACT_W) begin : g_bad_w
      $error("insn_alu_dec: widths must match the class, function and operation codes");
   end

   if (DECODE_SOP) begin : g_sop
      logic by_fn, hit_sub, hit_or, hit_and, hit_slt;

      always_comb begin
         by_fn   = (acls_i == ACLS_FUNC);
         hit_sub = (acls_i == ACLS_SUB) | (by_fn & (fn_lo_i == FN_SUB));
         hit_or  = (acls_i == ACLS_OR)  | (by_fn & (fn_lo_i == FN_OR));
         hit_and = by_fn & (fn_lo_i == FN_AND);
         hit_slt = by_fn & (fn_lo_i == FN_SLT);
         alu_op_o[2] = hit_sub | hit_slt;
         alu_op_o[1] = ~(hit_and | hit_or);
         alu_op_o[0] = hit_or | hit_slt;
      end
   end else begin : g_table
      always_comb begin
         case (acls_i)
            ACLS_ADD: alu_op_o = ALU_ADD;
            ACLS_SUB: alu_op_o = ALU_SUB;
            ACLS_OR:  alu_op_o = ALU_OR;
            ACLS_FUNC: begin
               case (fn_lo_i)
                  FN_ADD:  alu_op_o = ALU_ADD;
                  FN_SUB:  alu_op_o = ALU_SUB;
                  FN_AND:  alu_op_o = ALU_AND;
                  FN_OR:   alu_op_o = ALU_OR;
                  FN_SLT:  alu_op_o = ALU_SLT;
                  default: alu_op_o = ALU_ADD;
               endcase
            end
            default: alu_op_o = ALU_ADD;
         endcase
      end
   end

   // R9: outside the function-selected class, the result ignores the function bits
   always_comb begin
      if (acls_i == ACLS_SUB) begin
         a_r9_class_sub: assert (alu_op_o == ALU_SUB)
            else $error("R9: subtract class gave %b", alu_op_o);
      end
      if (acls_i == ACLS_OR) begin
         a_r9_class_or: assert (alu_op_o == ALU_OR)
            else $error("R9: or class gave %b", alu_op_o);
      end
   end

endmodule

// File: rtl/insn_ctl_dec.sv
module insn_ctl_dec
   import insn_ctl_pkg::*;
#(
   parameter int OP_W       = OPC_W,
   parameter int FN_W       = FNC_W,
   parameter int ACT_W      = insn_ctl_pkg::ACT_W,
   parameter bit DECODE_SOP = 1'b0
) (
   input  logic [OP_W-1:0]  opcode_i,
   input  logic [FN_W-1:0]  func_i,
   output logic             rd_sel_o,
   output logic             opb_imm_o,
   output logic             wb_mem_o,
   output logic             reg_we_o,
   output logic             mem_we_o,
   output logic             br_req_o,
   output logic             jmp_req_o,
   output logic             sext_o,
   output logic [ACT_W-1:0] alu_op_o
);

   localparam int FN_LO = FNLO_W;

   if (FN_W != FNC_W) begin : g_bad_fnw
      $error("insn_ctl_dec: FN_W must equal the function field width");
   end

   ctl_t             ctl;
   logic [FN_LO-1:0] fn_lo;
   logic             unused_fn_hi;

   assign fn_lo        = func_i[FN_LO-1:0];
   assign unused_fn_hi = ^func_i[FN_W-1:FN_LO];

   insn_main_dec #(
      .OP_W       (OP_W),
      .DECODE_SOP (DECODE_SOP)
   ) u_main (
      .opcode_i (opcode_i),
      .ctl_o    (ctl)
   );

   insn_alu_dec #(
      .AW         (AOP_W),
      .FW         (FN_LO),
      .CW         (ACT_W),
      .DECODE_SOP (DECODE_SOP)
   ) u_alu (
      .acls_i   (ctl.acls),
      .fn_lo_i  (fn_lo),
      .alu_op_o (alu_op_o)
   );

   assign rd_sel_o  = ctl.rd_sel;
   assign opb_imm_o = ctl.opb_imm;
   assign wb_mem_o  = ctl.wb_mem;
   assign reg_we_o  = ctl.reg_we;
   assign mem_we_o  = ctl.mem_we;
   assign br_req_o  = ctl.br_req;
   assign jmp_req_o = ctl.jmp_req;
   assign sext_o    = ctl.sext;

   always_comb begin
      // R1: the register-register opcode writes rd from two register operands
      if (opcode_i == OPC_REGREG) begin
         a_r1_regreg_write: assert (reg_we_o && rd_sel_o && !opb_imm_o && !mem_we_o)
            else $error("R1: register-register controls wrong");
      end
      // R2: subtract function code through both levels
      if (opcode_i == OPC_REGREG && fn_lo == FN_SUB) begin
         a_r2_sub_func: assert (alu_op_o == ALU_SUB)
            else $error("R2: sub function gave %b", alu_op_o);
      end
      // R5: a load takes write-back data from memory
      if (opcode_i == OPC_LDW) begin
         a_r5_load_wb: assert (wb_mem_o && reg_we_o && alu_op_o == ALU_ADD)
            else $error("R5: load controls wrong");
      end
      // R7: a branch compares by subtraction
      if (opcode_i == OPC_BEQ) begin
         a_r7_branch_sub: assert (br_req_o && alu_op_o == ALU_SUB && !reg_we_o)
            else $error("R7: branch controls wrong");
      end
      // R10: an opcode outside the set changes no state
      if (!(opcode_i inside {OPC_REGREG, OPC_ORI, OPC_LDW, OPC_STW, OPC_BEQ, OPC_JMP})) begin
         a_r10_unsupported_quiet: assert (!reg_we_o && !mem_we_o && !br_req_o && !jmp_req_o)
            else $error("R10: unsupported opcode %b drives a state change", opcode_i);
      end
   end

endmodule

// File: tb/sim_insn_ctl_dec.sv
module sim_insn_ctl_dec;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opc = '0;
   logic [5:0] fn  = '0;

   logic        t_rd, t_imm, t_wb, t_rwe, t_mwe, t_br, t_jmp, t_sx;
   logic [2:0]  t_alu;
   logic        s_rd, s_imm, s_wb, s_rwe, s_mwe, s_br, s_jmp, s_sx;
   logic [2:0]  s_alu;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   insn_ctl_dec u0 (
      .opcode_i (opc), .func_i (fn),
      .rd_sel_o (t_rd), .opb_imm_o (t_imm), .wb_mem_o (t_wb), .reg_we_o (t_rwe),
      .mem_we_o (t_mwe), .br_req_o (t_br), .jmp_req_o (t_jmp), .sext_o (t_sx),
      .alu_op_o (t_alu)
   );

   insn_ctl_dec #(.DECODE_SOP(1'b1)) u1 (
      .opcode_i (opc), .func_i (fn),
      .rd_sel_o (s_rd), .opb_imm_o (s_imm), .wb_mem_o (s_wb), .reg_we_o (s_rwe),
      .mem_we_o (s_mwe), .br_req_o (s_br), .jmp_req_o (s_jmp), .sext_o (s_sx),
      .alu_op_o (s_alu)
   );

   // packed as {rd_sel, opb_imm, wb_mem, reg_we, mem_we, br_req, jmp_req, sext, alu_op[2:0]}
   function automatic logic [10:0] expect_of(input logic [5:0] op, input logic [5:0] f);
      logic [2:0] r;
      case (f[3:0])
         4'b0000: r = 3'b010;
         4'b0010: r = 3'b110;
         4'b0100: r = 3'b000;
         4'b0101: r = 3'b001;
         4'b1010: r = 3'b111;
         default: r = 3'b010;
      endcase
      case (op)
         6'b000000: return {8'b1001_0000, r};
         6'b001101: return {8'b0101_0000, 3'b001};
         6'b100011: return {8'b0111_0001, 3'b010};
         6'b101011: return {8'b0100_1001, 3'b010};
         6'b000100: return {8'b0000_0101, 3'b110};
         6'b000010: return {8'b0000_0010, 3'b010};
         default:   return {8'b0000_0000, 3'b010};
      endcase
   endfunction

   task automatic apply_and_check(input logic [5:0] op, input logic [5:0] f, input string req);
      logic [10:0] e, g0, g1;
      @(negedge clk);
      opc = op;
      fn  = f;
      #2;
      e  = expect_of(op, f);
      g0 = {t_rd, t_imm, t_wb, t_rwe, t_mwe, t_br, t_jmp, t_sx, t_alu};
      g1 = {s_rd, s_imm, s_wb, s_rwe, s_mwe, s_br, s_jmp, s_sx, s_alu};
      n_chk++;
      if (g0 !== e || g1 !== e) begin
         n_bad++;
         $display("FAIL %s op=%b fn=%b: table got %b, sop got %b, expected %b",
                  req, op, f, g0, g1, e);
      end
   endtask

   task automatic t_initial_state();
      @(negedge clk);
      n_chk++;
      if ({t_rd, t_rwe, t_mwe, t_br, t_jmp, t_alu} !== {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010}) begin
         n_bad++;
         $display("FAIL R1 initial: got %b expected %b",
                  {t_rd, t_rwe, t_mwe, t_br, t_jmp, t_alu}, 8'b1100_0010);
      end
   endtask

   task automatic t_regreg_codes();
      logic [3:0] codes [5] = '{4'b0000, 4'b0010, 4'b0100, 4'b0101, 4'b1010};
      for (int k = 0; k < 5; k++)
         for (int h = 0; h < 4; h++)
            apply_and_check(6'b000000, {h[1:0], codes[k]}, "R1/R2");
   endtask

   task automatic t_regreg_other_func();
      for (int lo = 0; lo < 16; lo++)
         if (!(lo inside {0, 2, 4, 5, 10}))
            apply_and_check(6'b000000, {2'b10, lo[3:0]}, "R3");
   endtask

   task automatic t_ori();    apply_and_check(6'b001101, 6'b100000, "R4"); endtask
   task automatic t_load();   apply_and_check(6'b100011, 6'b000000, "R5"); endtask
   task automatic t_store();  apply_and_check(6'b101011, 6'b000010, "R6"); endtask
   task automatic t_branch(); apply_and_check(6'b000100, 6'b101010, "R7"); endtask
   task automatic t_jump();   apply_and_check(6'b000010, 6'b100100, "R8"); endtask

   task automatic t_func_ignored();
      logic [5:0] ops [5] = '{6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
      for (int k = 0; k < 5; k++)
         for (int f = 0; f < 64; f++)
            apply_and_check(ops[k], f[5:0], "R9");
   endtask

   task automatic t_unsupported();
      for (int o = 0; o < 64; o++)
         if (!(o inside {0, 2, 4, 13, 35, 43}))
            apply_and_check(o[5:0], 6'b101010, "R10");
   endtask

   task automatic t_full_sweep();
      for (int o = 0; o < 64; o++)
         for (int f = 0; f < 64; f++) begin
            apply_and_check(o[5:0], f[5:0], "R11 sweep");
            n_chk++;
            if ((int'(t_mwe) + int'(t_br) + int'(t_jmp)) > 1 || (t_rwe && t_mwe)) begin
               n_bad++;
               $display("FAIL R11 op=%b: got mwe/br/jmp/rwe=%b expected at most one effect",
                        o[5:0], {t_mwe, t_br, t_jmp, t_rwe});
            end
         end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_initial_state();
      t_regreg_codes();
      t_regreg_other_func();
      t_ori();
      t_load();
      t_store();
      t_branch();
      t_jump();
      t_func_ignored();
      t_unsupported();
      t_full_sweep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule